// File: doc/BRIEF.md
# Preloadable Interval Timer with Sticky Interrupt Status

This block is a down-counting interval timer. It is configured through one 16-bit write-only control word on a simple register write bus. The word carries an 8-bit preload count, a mode bit and a restart bit. The counter steps once per 100 µs time-base tick. A parameterised prescaler produces that tick from the system clock: 5000 cycles at the default 50 MHz.

When the count runs out, a sticky interrupt status flag is raised. It stays high until the status-clear input is pulsed. The interrupt line is that flag gated by an enable input.

The timer has two modes:
- **One-shot mode:** the timer stops after expiring and waits for another restart write.
- **Auto-reload mode:** the timer reloads the preload count and keeps running.

A preload of zero parks the timer. After reset the timer is idle and raises nothing until software starts it.

Top module: `itmr_top`

## Requirements
- R1: After reset the status flag and the interrupt line are low and the timer is idle, so no expiry occurs until a starting write arrives.
- R2: A control write with mode bit [1] = 0, restart bit [0] = 1 and a nonzero preload P in bits [15:8] starts the timer. The status flag rises at the clock edge exactly P × TICK_DIV cycles after the write edge. The timer then stops and expires no more.
- R3: A control write with mode bit [1] = 1 and a nonzero preload P starts the timer. The timer then expires every P × TICK_DIV cycles and reloads itself each time.
- R4: In auto mode (bit [1] = 1), restart bit [0] has no effect. An auto write with preload zero leaves the timer idle whatever bit [0] holds.
- R5: A starting write (restart in one-shot mode, or any auto write) whose preload is zero leaves the timer idle. The status flag is then never raised.
- R6: The status flag stays set until the cycle after stsClr is high. If an expiry and a clear fall in the same cycle, the flag ends up set.
- R7: irqOut is high exactly when the status flag is high and irqEn is high.
- R8: Bits [7:2] of the control word are ignored. Writes to any address other than CTRL_ADDR change nothing.
- R9: A restart write while the timer is counting discards the remaining count and starts again from the newly written preload.
- R10: A one-shot write with restart bit 0 updates the preload and mode, but does not restart or stop a count already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register write address |
| wrData | input | 16 | Register write data |
| stsClr | input | 1 | Clears the status flag (set wins on a tie) |
| irqEn | input | 1 | Interrupt line enable |
| irqStatus | output | 1 | Sticky expiry status flag |
| irqOut | output | 1 | Status flag gated by irqEn |

## Verification
The assertions take for granted that auto mode is only ever entered through a write, so an auto count always runs from a nonzero preload. They also assume that wrData is meaningful only in cycles where wrEn is high and wrAddr matches. The bench keeps to this by driving every bus field from tasks that change inputs on the falling edge only, with wrEn high for exactly one cycle per write. It reaches auto mode solely through full control-word writes. Clear pulses and long clear stretches are placed both away from and on expiry cycles, so both sides of the set-wins tie are exercised.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int DATA_W   = 16;
  localparam int PRE_W    = 8;
  localparam int PRE_LSB  = 8;
  localparam int MODE_BIT = 1;
  localparam int KICK_BIT = 0;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic             start;   // load counter and run
    logic             halt;    // park counter
    logic [PRE_W-1:0] loadVal; // value to load on start
  } tmrStrobe_t;
endpackage

// File: rtl/itmr_ctrl.sv
module itmr_ctrl
  import itmr_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output tmrStrobe_t        strb,
  output logic [PRE_W-1:0]  preload,
  output logic              autoMode
);
  logic             ctrlHit;
  logic [PRE_W-1:0] newPre;
  logic             newAuto;
  logic             kickReq;
  logic             trigger;
  logic             unusedRsvd;

  always_comb begin
    ctrlHit      = wrEn && (wrAddr == ADDR_W'(CTRL_ADDR));
    newPre       = wrData[PRE_LSB +: PRE_W];
    newAuto      = wrData[MODE_BIT];
    kickReq      = wrData[KICK_BIT] && !newAuto;
    trigger      = ctrlHit && (newAuto || kickReq);
    strb.start   = trigger && (newPre != '0);
    strb.halt    = trigger && (newPre == '0);
    strb.loadVal = newPre;
  end

  // reserved field carries no meaning
  assign unusedRsvd = ^wrData[PRE_LSB-1:MODE_BIT+1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preload  <= '0;
      autoMode <= 1'b0;
    end else if (ctrlHit) begin
      preload  <= newPre;
      autoMode <= newAuto;
    end
  end
endmodule

// File: rtl/itmr_dpath.sv
module itmr_dpath
  import itmr_pkg::*;
#(
  parameter int TICK_DIV = 5000
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strb,
  input  logic [PRE_W-1:0] preload,
  input  logic             autoMode,
  input  logic             stsClr,
  output logic             irqStatus
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic             busy;
  logic [PRE_W-1:0] cnt;
  logic             tick;
  logic             expire;

  generate
    if (TICK_DIV > 1) begin : g_presc
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] presc;
      always_ff @(posedge clk) begin
        if (!rstN || strb.start || strb.halt || !busy || presc == LAST)
          presc <= '0;
        else
          presc <= presc + 1'b1;
      end
      assign tick = busy && (presc == LAST);
    end else begin : g_nopresc
      assign tick = busy;
    end
  endgenerate

  assign expire = tick && (cnt == PRE_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (strb.start) begin
      busy <= 1'b1;
      cnt  <= strb.loadVal;
    end else if (strb.halt) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (expire) begin
      busy <= autoMode;
      cnt  <= autoMode ? preload : '0;
    end else if (tick) begin
      cnt  <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqStatus <= 1'b0;
    else       irqStatus <= expire || (irqStatus && !stsClr);
  end
endmodule

// File: rtl/itmr_top.sv
module itmr_top
  import itmr_pkg::*;
#(
  parameter int TICK_DIV  = 5000,
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              stsClr,
  input  logic              irqEn,
  output logic              irqStatus,
  output logic              irqOut
);
  tmrStrobe_t       strb;
  logic [PRE_W-1:0] preload;
  logic             autoMode;

  itmr_ctrl #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .preload(preload), .autoMode(autoMode)
  );

  itmr_dpath #(.TICK_DIV(TICK_DIV)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .preload(preload),
    .autoMode(autoMode), .stsClr(stsClr), .irqStatus(irqStatus)
  );

  assign irqOut = irqStatus && irqEn;
endmodule

// File: rtl/itmr_chk.sv
module itmr_chk
  import itmr_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              stsClr,
  input logic              irqEn,
  input logic              irqStatus,
  input logic              irqOut,
  input logic              busy,
  input logic [PRE_W-1:0]  cnt
);
  logic             ctrlHit;
  logic [PRE_W-1:0] wPre;
  assign ctrlHit = wrEn && (wrAddr == ADDR_W'(CTRL_ADDR));
  assign wPre    = wrData[PRE_LSB +: PRE_W];

  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !irqStatus) |=> !irqStatus);

  p_busy_nonzero_r2: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (cnt != '0));

  p_restart_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlHit && !wrData[MODE_BIT] && wrData[KICK_BIT] && wPre != '0)
      |=> (busy && cnt == $past(wPre)));

  p_auto_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlHit && wrData[MODE_BIT] && wPre != '0) |=> (busy && cnt == $past(wPre)));

  p_zero_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlHit && (wrData[MODE_BIT] || wrData[KICK_BIT]) && wPre == '0) |=> !busy);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (irqStatus && !stsClr) |=> irqStatus);

  p_irq_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> !irqOut);

  p_irq_on_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irqEn && irqStatus) |-> irqOut);

  p_other_addr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !ctrlHit) |=> !busy);
endmodule

bind itmr_top itmr_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .stsClr(stsClr), .irqEn(irqEn), .irqStatus(irqStatus), .irqOut(irqOut),
  .busy(uDp.busy), .cnt(uDp.cnt)
);

// File: tb/sim_itmr_top.sv
`timescale 1ns/1ps
module sim_itmr_top;
  localparam int N      = 4;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [15:0]       wrData = '0;
  logic              stsClr = 1'b0;
  logic              irqEn = 1'b1;
  logic              irqStatus, irqOut;

  int    nChecks = 0;
  int    nFail = 0;
  string phase = "R1 reset";

  always #4 clk = ~clk;

  itmr_top #(.TICK_DIV(N), .ADDR_W(ADDR_W), .CTRL_ADDR(0)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .stsClr(stsClr), .irqEn(irqEn), .irqStatus(irqStatus), .irqOut(irqOut)
  );

  // behavioural reference: remaining cycles until expiry
  int mRem = 0;
  int mPre = 0;
  bit mRun = 0;
  bit mAuto = 0;
  bit mSts = 0;

  always @(posedge clk) begin
    bit setNow;
    setNow = 0;
    if (!rstN) begin
      mRem = 0; mPre = 0; mRun = 0; mAuto = 0; mSts = 0;
    end else begin
      if (mRun) begin
        mRem = mRem - 1;
        if (mRem == 0) begin
          setNow = 1;
          if (mAuto) mRem = mPre * N;
          else       mRun = 0;
        end
      end
      if (wrEn && wrAddr == 0) begin
        mPre  = wrData[15:8];
        mAuto = wrData[1];
        if (wrData[1] || wrData[0]) begin
          if (mPre != 0) begin mRun = 1; mRem = mPre * N; end
          else mRun = 0;
        end
      end
      mSts = setNow || (mSts && !stsClr);
    end
    #2;
    nChecks++;
    if (irqStatus !== mSts || irqOut !== (mSts && irqEn)) begin
      nFail++;
      $display("FAIL %s: irqStatus=%0b irqOut=%0b expected %0b %0b",
               phase, irqStatus, irqOut, mSts, mSts && irqEn);
    end
  end

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0; wrAddr = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clrPulse();
    @(negedge clk); stsClr = 1'b1;
    @(negedge clk); stsClr = 1'b0;
  endtask

  task automatic expectSts(input string req, input logic exp);
    nChecks++;
    if (irqStatus !== exp) begin
      nFail++;
      $display("FAIL %s: irqStatus=%0b expected %0b", req, irqStatus, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(20);
    expectSts("R1 idle after reset", 1'b0);

    phase = "R2 one-shot";
    doWrite(0, 16'h0301);
    idle(40);
    expectSts("R2 expired", 1'b1);

    phase = "R6 clear";
    clrPulse();
    idle(30);
    expectSts("R2 no second expiry", 1'b0);

    phase = "R5 zero preload";
    doWrite(0, 16'h0001);
    idle(30);
    expectSts("R5 zero preload idle", 1'b0);

    phase = "R4 auto kick ignored";
    doWrite(0, 16'h0003);
    idle(30);
    expectSts("R4 auto zero idle", 1'b0);

    phase = "R3 auto reload";
    doWrite(0, 16'h0202);
    idle(10);
    clrPulse();
    idle(10);
    expectSts("R3 re-expired", 1'b1);

    phase = "R6 set wins";
    @(negedge clk); stsClr = 1'b1;
    idle(30);
    @(negedge clk); stsClr = 1'b0;

    phase = "R7 irq gate";
    idle(12);
    irqEn = 1'b0;
    idle(12);
    nChecks++;
    if (irqOut !== 1'b0) begin
      nFail++;
      $display("FAIL R7: irqOut=%0b expected 0", irqOut);
    end
    irqEn = 1'b1;

    phase = "R4 auto with kick";
    doWrite(0, 16'h0503);
    idle(45);

    phase = "R10 stop via mode";
    doWrite(0, 16'h0000);
    idle(30);
    clrPulse();
    idle(30);
    expectSts("R10 stopped after last expiry", 1'b0);

    phase = "R8 other address";
    doWrite(1, 16'h0301);
    idle(30);
    expectSts("R8 other address ignored", 1'b0);

    phase = "R8 reserved bits";
    doWrite(0, 16'h02FD);
    idle(12);
    clrPulse();

    phase = "R9 restart mid-count";
    doWrite(0, 16'h0401);
    idle(6);
    doWrite(0, 16'h0201);
    idle(6);
    expectSts("R9 not yet", 1'b0);
    idle(6);
    expectSts("R9 expired from new preload", 1'b1);

    phase = "R10 write keeps count";
    clrPulse();
    doWrite(0, 16'h0301);
    idle(3);
    doWrite(0, 16'h0700);
    idle(20);
    clrPulse();
    idle(10);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule